// File: doc/BRIEF.md
# Configuration Window Address Translator

This block sits behind a simple memory-mapped slave port and converts accesses that land in a fixed 4 MiB physical window into configuration requests for a downstream agent. The offset inside the window holds two parts. The low bits give the function and register number and are passed on unchanged. A select field higher up holds a one-hot device choice. The block turns that choice into a small device number by finding the lowest bit of the field that is set.

Reads and writes use the same translation. Write data is moved onto the byte lanes given by the low address bits, with little-endian ordering. Read data that returns from the agent is moved back down from those lanes and passed to the requester. The requester holds its strobe until the block acknowledges the access. The downstream request uses a valid/ready handshake. Partial accesses that are not naturally aligned are refused at the slave port and never reach the downstream agent.

Top module: `cfgwin_bridge`

## Requirements
- R1: Only accesses with 0x8080_0000 <= address < 0x80C0_0000 produce a downstream request or an acknowledge. Any other address leaves cfg_valid and up_ack low for as long as the strobe is held.
- R2: Bits 10..0 of cfg_addr equal bits 10..0 of the access address.
- R3: Bits 14..11 of cfg_addr hold the index (0 to 10) of the lowest set bit among address bits 21..11. Index i means address bit 11+i.
- R4: When address bits 21..11 are all zero, bits 14..11 of cfg_addr equal 11.
- R5: For a write, cfg_write is 1. Size code 0 selects 1 byte, 1 selects 2 bytes and 2 selects 4 bytes. With lane L = address[1:0], cfg_be is 0001, 0011 or 1111 shifted left by L. cfg_wdata is up_wdata masked to the access size and shifted left by 8*L bits.
- R6: For a read, cfg_write is 0. The block asserts up_rvalid together with up_ack. up_rdata is cfg_rdata shifted right by 8*L bits and masked to the access size. Read data may arrive in the same cycle as the accept or in any later cycle.
- R7: The block raises cfg_valid one cycle after an accepted access is presented. It then holds cfg_valid, cfg_addr, cfg_be, cfg_wdata and cfg_write stable until a cycle in which cfg_ready is high. It issues exactly one request per access.
- R8: The block raises up_ack for exactly one cycle per access. For a write this is the cycle after the accept. For a read it is the cycle after the read data is taken.
- R9: The block refuses, and does not forward, three cases inside the window: a 2-byte access with address bit 0 set, a 4-byte access with address[1:0] not zero, and size code 3. In the cycle after the access is presented, it raises up_ack and up_err for one cycle. For a read it also raises up_rvalid with up_rdata = 0xFFFF_FFFF.
- R10: A synchronous active-low reset drops any pending request and clears cfg_valid and up_ack.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| up_rd | input | 1 | Read strobe, held until up_ack |
| up_wr | input | 1 | Write strobe, held until up_ack |
| up_addr | input | 32 | Physical access address |
| up_size | input | 2 | Access size code: 0 = 1 byte, 1 = 2 bytes, 2 = 4 bytes |
| up_wdata | input | 32 | Write value, right-aligned |
| up_ack | output | 1 | One-cycle completion pulse |
| up_err | output | 1 | Misalignment refusal, valid with up_ack |
| up_rvalid | output | 1 | Read data valid |
| up_rdata | output | 32 | Read value, right-aligned |
| cfg_valid | output | 1 | Configuration request valid |
| cfg_ready | input | 1 | Agent accepts the request |
| cfg_write | output | 1 | 1 = write, 0 = read |
| cfg_addr | output | 15 | Translated address {device, offset[10:0]} |
| cfg_be | output | 4 | Byte enables |
| cfg_wdata | output | 32 | Lane-aligned write data |
| cfg_rvalid | input | 1 | Agent read data valid |
| cfg_rdata | input | 32 | Lane-aligned read data from agent |

## Verification
Two events can land in the same cycle: the agent accepting a read request, and the agent returning the read data. The bench provokes this by raising cfg_ready and cfg_rvalid together. It then expects a single acknowledge one cycle later with correctly extracted data, and no second request or stray response. The same read is also run with data returned one and several cycles after the accept, so each path to completion is compared cycle by cycle against the bench's own timeline.

// File: rtl/cfgwin_pkg.sv
// Shared types for the configuration window translator.
// Assumes: the state encoding is local to the translator; nothing outside decodes it.
package cfgwin_pkg;
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_REQ  = 2'd1,
        ST_WAIT = 2'd2,
        ST_DONE = 2'd3
    } bridge_state_e;

    localparam logic [1:0] SIZE_BYTE = 2'd0;
    localparam logic [1:0] SIZE_HALF = 2'd1;
    localparam logic [1:0] SIZE_WORD = 2'd2;
endpackage

// File: rtl/cfgwin_decode.sv
// Window hit, alignment check and address translation, all combinational.
// The device number is the index of the lowest set bit of the select field.
// If no bit is set, the number is SEL_N.
// Assumes: SEL_LO + SEL_N <= WIN_LOG2, and the register offset is the SEL_LO low bits.
module cfgwin_decode #(
    parameter int ADDR_W = 32,
    parameter logic [ADDR_W-1:0] WIN_BASE = 32'h8080_0000,
    parameter int WIN_LOG2 = 22,
    parameter int SEL_LO = 11,
    parameter int SEL_N = 11,
    parameter int DEV_W = $clog2(SEL_N + 1)
) (
    input  logic [ADDR_W-1:0]       addr,
    input  logic [1:0]              size,
    output logic                    hit,
    output logic                    reject,
    output logic [SEL_LO+DEV_W-1:0] xaddr
);
    import cfgwin_pkg::*;

    logic [DEV_W-1:0] dev;

    // Window match on the bits above the window size.
    always_comb hit = (addr[ADDR_W-1:WIN_LOG2] == WIN_BASE[ADDR_W-1:WIN_LOG2]);

    // Priority search: the lowest set select bit writes last, so it wins.
    always_comb begin
        dev = DEV_W'(SEL_N);
        for (int i = SEL_N - 1; i >= 0; i--) begin
            if (addr[SEL_LO + i]) dev = DEV_W'(i);
        end
    end

    // Translated address: device number above the passed-through offset.
    always_comb xaddr = {dev, addr[SEL_LO-1:0]};

    // Natural alignment per size code; size code 3 is always refused.
    always_comb begin
        case (size)
            SIZE_BYTE: reject = 1'b0;
            SIZE_HALF: reject = addr[0];
            SIZE_WORD: reject = |addr[1:0];
            default:   reject = 1'b1;
        endcase
    end
endmodule

// File: rtl/cfgwin_lanes.sv
// Little-endian byte-lane steering for writes and extraction for reads.
// Assumes: the access is already known to fit in the word, and DATA_W is a multiple of 8.
module cfgwin_lanes #(
    parameter int DATA_W = 32,
    parameter int LANES = DATA_W / 8,
    parameter int LANE_W = $clog2(LANES)
) (
    input  logic [LANE_W-1:0] lane,
    input  logic [1:0]        size,
    input  logic [DATA_W-1:0] wdata,
    input  logic [DATA_W-1:0] lane_word,
    output logic [LANES-1:0]  be,
    output logic [DATA_W-1:0] wdata_lane,
    output logic [DATA_W-1:0] rdata_val
);
    logic [LANES-1:0]    be_base;
    logic [DATA_W-1:0]   keep;
    logic [LANE_W+2:0]   shamt;

    // Build the unshifted byte enables and data mask from the size code.
    always_comb begin
        be_base = '0;
        keep    = '0;
        for (int b = 0; b < LANES; b++) begin
            if (b < (32'd1 << size)) begin
                be_base[b]      = 1'b1;
                keep[8*b +: 8]  = 8'hFF;
            end
        end
    end

    // Move data up to the addressed lanes and back down.
    always_comb begin
        shamt      = {lane, 3'b000};
        be         = be_base << lane;
        wdata_lane = (wdata & keep) << shamt;
        rdata_val  = (lane_word >> shamt) & keep;
    end
endmodule

// File: rtl/cfgwin_bridge.sv
// Top level: slave-port access to configuration request translator.
// It captures one access, forwards it with a valid/ready handshake, and
// returns a one-cycle acknowledge (with read data for reads).
// Assumes: the requester holds strobe, address, size and data until up_ack,
// and the agent returns read data only in or after the accept cycle.
module cfgwin_bridge #(
    parameter int ADDR_W = 32,
    parameter int DATA_W = 32,
    parameter logic [ADDR_W-1:0] WIN_BASE = 32'h8080_0000,
    parameter int WIN_LOG2 = 22,
    parameter int SEL_LO = 11,
    parameter int SEL_N = 11
) (
    input  logic                                 clk,
    input  logic                                 rst_n,
    input  logic                                 up_rd,
    input  logic                                 up_wr,
    input  logic [ADDR_W-1:0]                    up_addr,
    input  logic [1:0]                           up_size,
    input  logic [DATA_W-1:0]                    up_wdata,
    output logic                                 up_ack,
    output logic                                 up_err,
    output logic                                 up_rvalid,
    output logic [DATA_W-1:0]                    up_rdata,
    output logic                                 cfg_valid,
    input  logic                                 cfg_ready,
    output logic                                 cfg_write,
    output logic [SEL_LO+$clog2(SEL_N+1)-1:0]    cfg_addr,
    output logic [DATA_W/8-1:0]                  cfg_be,
    output logic [DATA_W-1:0]                    cfg_wdata,
    input  logic                                 cfg_rvalid,
    input  logic [DATA_W-1:0]                    cfg_rdata
);
    import cfgwin_pkg::*;

    localparam int DEV_W  = $clog2(SEL_N + 1);
    localparam int CFG_AW = SEL_LO + DEV_W;
    localparam int LANES  = DATA_W / 8;
    localparam int LANE_W = $clog2(LANES);

    bridge_state_e      state;
    logic               hit, reject, access;
    logic [CFG_AW-1:0]  xaddr;
    logic [LANES-1:0]   be_n;
    logic [DATA_W-1:0]  wdata_n, rdata_n;

    cfgwin_decode #(
        .ADDR_W(ADDR_W), .WIN_BASE(WIN_BASE), .WIN_LOG2(WIN_LOG2),
        .SEL_LO(SEL_LO), .SEL_N(SEL_N), .DEV_W(DEV_W)
    ) u_decode (
        .addr(up_addr), .size(up_size), .hit(hit), .reject(reject), .xaddr(xaddr)
    );

    cfgwin_lanes #(
        .DATA_W(DATA_W), .LANES(LANES), .LANE_W(LANE_W)
    ) u_lanes (
        .lane(up_addr[LANE_W-1:0]), .size(up_size), .wdata(up_wdata),
        .lane_word(cfg_rdata), .be(be_n), .wdata_lane(wdata_n), .rdata_val(rdata_n)
    );

    // An access is a strobe aimed inside the window.
    always_comb access = (up_rd | up_wr) & hit;

    // Access sequencer: capture, forward, wait for data, acknowledge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state     <= ST_IDLE;
            cfg_valid <= 1'b0;
            cfg_write <= 1'b0;
            cfg_addr  <= '0;
            cfg_be    <= '0;
            cfg_wdata <= '0;
            up_ack    <= 1'b0;
            up_err    <= 1'b0;
            up_rvalid <= 1'b0;
            up_rdata  <= '0;
        end else begin
            up_ack    <= 1'b0;
            up_err    <= 1'b0;
            up_rvalid <= 1'b0;
            case (state)
                ST_IDLE: begin
                    if (access && reject) begin
                        state     <= ST_DONE;
                        up_ack    <= 1'b1;
                        up_err    <= 1'b1;
                        up_rvalid <= ~up_wr;
                        up_rdata  <= '1;
                    end else if (access) begin
                        state     <= ST_REQ;
                        cfg_valid <= 1'b1;
                        cfg_write <= up_wr;
                        cfg_addr  <= xaddr;
                        cfg_be    <= be_n;
                        cfg_wdata <= wdata_n;
                    end
                end
                ST_REQ: begin
                    if (cfg_ready) begin
                        cfg_valid <= 1'b0;
                        if (cfg_write) begin
                            state  <= ST_DONE;
                            up_ack <= 1'b1;
                        end else if (cfg_rvalid) begin
                            state     <= ST_DONE;
                            up_ack    <= 1'b1;
                            up_rvalid <= 1'b1;
                            up_rdata  <= rdata_n;
                        end else begin
                            state <= ST_WAIT;
                        end
                    end
                end
                ST_WAIT: begin
                    if (cfg_rvalid) begin
                        state     <= ST_DONE;
                        up_ack    <= 1'b1;
                        up_rvalid <= 1'b1;
                        up_rdata  <= rdata_n;
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/cfgwin_bridge_chk.sv
// Protocol checker for the translator, attached through bind.
// Assumes: the requester holds its address while a request is outstanding.
module cfgwin_bridge_chk #(
    parameter int ADDR_W = 32,
    parameter int DATA_W = 32,
    parameter int SEL_LO = 11,
    parameter int CFG_AW = 15
) (
    input logic              clk,
    input logic              rst_n,
    input logic              up_rd,
    input logic              up_wr,
    input logic [ADDR_W-1:0] up_addr,
    input logic              up_ack,
    input logic              up_err,
    input logic              up_rvalid,
    input logic [DATA_W-1:0] up_rdata,
    input logic              cfg_valid,
    input logic              cfg_ready,
    input logic              cfg_write,
    input logic [CFG_AW-1:0] cfg_addr,
    input logic [DATA_W/8-1:0] cfg_be,
    input logic [DATA_W-1:0] cfg_wdata
);
    // A request only exists while the requester is strobing.
    assert_req_needs_strobe_R1: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_valid |-> (up_rd || up_wr));

    // The offset bits pass through untouched.
    assert_offset_pass_R2: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_valid |-> cfg_addr[SEL_LO-1:0] == up_addr[SEL_LO-1:0]);

    // A forwarded request always enables at least one lane.
    assert_lanes_nonzero_R5: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_valid |-> cfg_be != '0);

    // A stalled request keeps all its fields.
    assert_hold_request_R7: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_valid && !cfg_ready |=> cfg_valid && $stable(cfg_addr) && $stable(cfg_be)
            && $stable(cfg_wdata) && $stable(cfg_write));

    // Acknowledge lasts one cycle.
    assert_ack_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
        up_ack |=> !up_ack);

    // Read data is only offered with an acknowledge.
    assert_rvalid_with_ack_R6: assert property (@(posedge clk) disable iff (!rst_n)
        up_rvalid |-> up_ack);

    // A refusal is an acknowledge with no request in flight.
    assert_err_shape_R9: assert property (@(posedge clk) disable iff (!rst_n)
        up_err |-> up_ack && !cfg_valid);

    // Refused reads return all ones.
    assert_err_data_R9: assert property (@(posedge clk) disable iff (!rst_n)
        up_err && up_rvalid |-> up_rdata == '1);

    // Leaving reset there is nothing pending.
    assert_reset_clear_R10: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> !cfg_valid && !up_ack);
endmodule

bind cfgwin_bridge cfgwin_bridge_chk #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .SEL_LO(SEL_LO), .CFG_AW(CFG_AW)
) u_chk (
    .clk(clk), .rst_n(rst_n), .up_rd(up_rd), .up_wr(up_wr), .up_addr(up_addr),
    .up_ack(up_ack), .up_err(up_err), .up_rvalid(up_rvalid), .up_rdata(up_rdata),
    .cfg_valid(cfg_valid), .cfg_ready(cfg_ready), .cfg_write(cfg_write),
    .cfg_addr(cfg_addr), .cfg_be(cfg_be), .cfg_wdata(cfg_wdata)
);

// File: tb/tb_cfgwin_bridge.sv
// Bench: drives the slave port, plays the downstream agent, and compares
// every sampled cycle against timing and values computed here.
module tb_cfgwin_bridge;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        up_rd = 1'b0, up_wr = 1'b0;
    logic [31:0] up_addr = '0;
    logic [1:0]  up_size = '0;
    logic [31:0] up_wdata = '0;
    logic        up_ack, up_err, up_rvalid;
    logic [31:0] up_rdata;
    logic        cfg_valid, cfg_write;
    logic        cfg_ready = 1'b0, cfg_rvalid = 1'b0;
    logic [14:0] cfg_addr;
    logic [3:0]  cfg_be;
    logic [31:0] cfg_wdata;
    logic [31:0] cfg_rdata = '0;

    int vectors = 0;
    int miscompares = 0;
    bit finished = 0;

    always #5 clk = ~clk;

    cfgwin_bridge dut (
        .clk(clk), .rst_n(rst_n), .up_rd(up_rd), .up_wr(up_wr), .up_addr(up_addr),
        .up_size(up_size), .up_wdata(up_wdata), .up_ack(up_ack), .up_err(up_err),
        .up_rvalid(up_rvalid), .up_rdata(up_rdata), .cfg_valid(cfg_valid),
        .cfg_ready(cfg_ready), .cfg_write(cfg_write), .cfg_addr(cfg_addr),
        .cfg_be(cfg_be), .cfg_wdata(cfg_wdata), .cfg_rvalid(cfg_rvalid),
        .cfg_rdata(cfg_rdata)
    );

    task automatic check(input string rq, input logic [63:0] act, input logic [63:0] exp);
        vectors++;
        if (act !== exp) begin
            miscompares++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", rq, act, exp, $time);
        end
    endtask

    function automatic int exp_dev(input logic [31:0] a);
        int d = 11;
        for (int i = 10; i >= 0; i--) if (a[11 + i]) d = i;
        return d;
    endfunction

    function automatic logic [31:0] exp_mask(input logic [1:0] s);
        return (s == 2'd0) ? 32'h0000_00FF : (s == 2'd1) ? 32'h0000_FFFF : 32'hFFFF_FFFF;
    endfunction

    function automatic logic [3:0] exp_be(input logic [1:0] s, input logic [1:0] l);
        logic [3:0] base = (s == 2'd0) ? 4'b0001 : (s == 2'd1) ? 4'b0011 : 4'b1111;
        return base << l;
    endfunction

    task automatic drop;
        up_rd = 1'b0; up_wr = 1'b0;
    endtask

    // Translated, aligned access; rdly = stall cycles before accept,
    // ddly = cycles from accept to read data (0 = same cycle as accept).
    task automatic run_ok(input bit rd, input logic [31:0] a, input logic [1:0] s,
                          input logic [31:0] wd, input int rdly, input int ddly,
                          input logic [31:0] word);
        int dv = exp_dev(a);
        logic [1:0] l = a[1:0];
        @(negedge clk);
        up_rd = rd; up_wr = !rd; up_addr = a; up_size = s; up_wdata = wd;
        @(negedge clk);
        check("R7 request raised", {63'd0, cfg_valid}, 64'd1);
        check("R2 offset bits", {53'd0, cfg_addr[10:0]}, {53'd0, a[10:0]});
        check(dv == 11 ? "R4 empty select gives 11" : "R3 lowest select index",
              {60'd0, cfg_addr[14:11]}, 64'(dv));
        check(rd ? "R6 read direction" : "R5 write direction", {63'd0, cfg_write}, {63'd0, !rd});
        if (!rd) begin
            check("R5 byte enables", {60'd0, cfg_be}, {60'd0, exp_be(s, l)});
            check("R5 lane data", {32'd0, cfg_wdata}, {32'd0, (wd & exp_mask(s)) << (8 * l)});
        end
        for (int k = 0; k < rdly; k++) begin
            @(negedge clk);
            check("R7 held while stalled", {48'd0, cfg_valid, cfg_addr}, {48'd0, 1'b1, 4'(dv), a[10:0]});
            check("R8 no early ack", {63'd0, up_ack}, 64'd0);
        end
        cfg_ready = 1'b1;
        if (rd && ddly == 0) begin cfg_rvalid = 1'b1; cfg_rdata = word; end
        @(negedge clk);
        cfg_ready = 1'b0; cfg_rvalid = 1'b0;
        check("R7 single request", {63'd0, cfg_valid}, 64'd0);
        if (rd && ddly > 0) begin
            check("R8 no ack before data", {63'd0, up_ack}, 64'd0);
            for (int k = 1; k < ddly; k++) begin
                @(negedge clk);
                check("R8 no ack before data", {62'd0, up_ack, cfg_valid}, 64'd0);
            end
            cfg_rvalid = 1'b1; cfg_rdata = word;
            @(negedge clk);
            cfg_rvalid = 1'b0;
        end
        check("R8 ack raised", {62'd0, up_ack, up_err}, 64'b10);
        check(rd ? "R6 rvalid on read" : "R8 no rvalid on write", {63'd0, up_rvalid}, {63'd0, rd});
        if (rd) check("R6 extracted data", {32'd0, up_rdata}, {32'd0, (word >> (8 * l)) & exp_mask(s)});
        drop();
        @(negedge clk);
        check("R8 ack single cycle", {62'd0, up_ack, cfg_valid}, 64'd0);
    endtask

    // Out-of-window access: nothing may happen while the strobe is held.
    task automatic run_outside(input logic [31:0] a);
        @(negedge clk);
        up_rd = 1'b1; up_addr = a; up_size = 2'd2;
        for (int k = 0; k < 4; k++) begin
            @(negedge clk);
            check("R1 outside window ignored", {62'd0, cfg_valid, up_ack}, 64'd0);
        end
        drop();
    endtask

    // Misaligned or bad-size access: refused without a request.
    task automatic run_refused(input bit rd, input logic [31:0] a, input logic [1:0] s);
        @(negedge clk);
        up_rd = rd; up_wr = !rd; up_addr = a; up_size = s; up_wdata = 32'hDEAD_BEEF;
        @(negedge clk);
        check("R9 refusal ack and err", {61'd0, up_ack, up_err, cfg_valid}, 64'b110);
        check("R9 rvalid on refused read", {63'd0, up_rvalid}, {63'd0, rd});
        if (rd) check("R9 all-ones data", {32'd0, up_rdata}, 64'hFFFF_FFFF);
        drop();
        @(negedge clk);
        check("R9 refusal single cycle", {61'd0, up_ack, up_err, cfg_valid}, 64'd0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check("R10 reset state", {61'd0, cfg_valid, up_ack, up_err}, 64'd0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R10 idle after reset", {62'd0, cfg_valid, up_ack}, 64'd0);

        run_ok(0, 32'h8080_0803, 2'd0, 32'h0000_00A5, 0, 0, 32'h0);
        run_ok(0, 32'h80A0_0102, 2'd1, 32'hFFFF_1234, 2, 0, 32'h0);
        run_ok(0, 32'h8084_2040, 2'd2, 32'hCAFE_F00D, 0, 0, 32'h0);
        run_ok(1, 32'h8080_07FD, 2'd0, 32'h0, 0, 0, 32'h1122_3344);
        run_ok(1, 32'h8080_8006, 2'd1, 32'h0, 1, 3, 32'h1122_3344);
        run_ok(1, 32'h80BF_F000, 2'd2, 32'h0, 0, 1, 32'h89AB_CDEF);
        run_ok(1, 32'h80BF_FFFC, 2'd2, 32'h0, 3, 0, 32'h0BAD_CAFE);
        run_ok(1, 32'h8080_0000, 2'd1, 32'h0, 0, 2, 32'h5566_7788);

        run_outside(32'h807F_FFFC);
        run_outside(32'h80C0_0000);
        run_outside(32'h0000_0CF8);

        run_refused(1, 32'h8080_1001, 2'd1);
        run_refused(0, 32'h8080_1002, 2'd2);
        run_refused(1, 32'h8080_1000, 2'd3);

        // Reset while a request is outstanding.
        @(negedge clk);
        up_rd = 1'b1; up_addr = 32'h8081_0010; up_size = 2'd2;
        @(negedge clk);
        check("R10 request before reset", {63'd0, cfg_valid}, 64'd1);
        rst_n = 1'b0; drop();
        @(negedge clk);
        check("R10 reset drops request", {62'd0, cfg_valid, up_ack}, 64'd0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        check("R10 stays idle", {62'd0, cfg_valid, up_ack}, 64'd0);

        finished = 1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            miscompares++;
            $display("FAIL watchdog expired: run hung");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
            $finish;
        end
    end
endmodule